// File: doc/BRIEF.md
# Ternary Fault-Pattern Guard

This block watches a vector of critical control signals every cycle and compares it against a small table of programmable ternary patterns. Each pattern describes a known erroneous control state that was found after the chip was built and loaded into the table in the field. A pattern is made of bits that must hold a given value and bits that are don't-care. When any valid pattern matches while the system runs normally, the block asks the recovery logic to drain the pipeline. Once the drain is reported complete, it holds the system in a simple, fully verified fallback mode.

The fallback mode lasts for a programmable number of retired instructions. After that the block returns to normal operation and raises an exit request, which stays up until the recovery logic acknowledges it. A saturating counter records every cycle in which some pattern matched, including cycles in which the match could not change the mode. Entries are written one at a time through a simple write port carrying an index, a value, a care mask and a valid flag.

Top module: `fault_pattern_guard`

## Requirements
- R1: After reset, drainReq, fallbackActive and exitReq are 0, hitCount is 0, and every table entry is invalid, so no signal vector is counted or starts a drain.
- R2: An entry matches when its valid bit is set and ((sigVec ^ value) & care) == 0; a care bit of 1 makes that signal bit compared and a care bit of 0 makes it don't-care.
- R3: An entry written with cfgValid = 0 never matches, whatever its value and care mask.
- R4: A write to entry cfgIdx takes effect on the cycle after cfgWrEn; in the write cycle that entry matches neither with its old contents nor with its new ones.
- R5: While in normal mode, a cycle with any match makes drainReq 1 from the next cycle on; it stays 1 until drainDone is seen.
- R6: While draining, drainDone makes fallbackActive 1 and drainReq 0 from the next cycle on.
- R7: The fallback mode ends with the retireValid pulse that completes the fallbackLen retirements counted from the cycle drainDone was seen (a length of 0 behaves as 1); fallbackActive is 0 and exitReq is 1 from the next cycle on.
- R8: exitReq stays 1 until a cycle with exitAck, and is 0 from the cycle after that.
- R9: A match while draining or in fallback does not change drainReq or fallbackActive.
- R10: hitCount increases by one for every cycle in which at least one entry matches, in any mode, and stays at its all-ones value once reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Write one table entry this cycle |
| cfgIdx | input | 4 | Index of the entry being written |
| cfgValue | input | 32 | Expected signal values for the entry |
| cfgCare | input | 32 | Per-bit compare enable for the entry (1 = compared) |
| cfgValid | input | 1 | Valid flag stored with the entry |
| fallbackLen | input | 16 | Retired-instruction count of a fallback episode, sampled with drainDone |
| sigVec | input | 32 | Critical control signals compared every cycle |
| drainDone | input | 1 | Recovery logic reports that the pipeline is drained |
| retireValid | input | 1 | One instruction retired in fallback mode |
| exitAck | input | 1 | Recovery logic acknowledges the exit request |
| drainReq | output | 1 | Request to drain before entering fallback mode |
| fallbackActive | output | 1 | System is held in fallback mode |
| exitReq | output | 1 | Fallback mode finished, return to normal operation |
| hitCount | output | 8 | Saturating count of cycles with a match |

## Verification
The pattern table is filled with entries of different shapes: one that compares the low byte, one that compares the upper half-word, one that compares only two scattered bits, and one that is invalid with an all-don't-care mask. Signal vectors are then presented that satisfy exactly the compared bits while the don't-care bits vary. Other vectors break a single compared bit, and some would match only the invalid entry, so each vector separates compared bits from don't-care bits or valid entries from invalid ones. Further tests rewrite an entry while the signal vector hits its old contents and while it hits its new contents, which isolates the one-cycle write masking. The mode sequence is driven with gaps between retirements, with a zero length, and with a long run of matches that saturates the counter.

// File: rtl/fpg_pkg.sv
`timescale 1ns/1ps
package fpg_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_DRAIN    = 2'd1,
    MODE_FALLBACK = 2'd2
  } mode_e;

  // strobes from the mode control into the datapath
  typedef struct packed {
    logic hitInc;    // count one matching cycle
    logic exitLoad;  // load the fallback length
    logic exitDec;   // one retirement consumed
  } ctlStrb_t;

endpackage

// File: rtl/fpg_datapath.sv
`timescale 1ns/1ps
module fpg_datapath
  import fpg_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int SIG_W = 32,
  parameter int HIT_W = 8,
  parameter int LEN_W = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [SIG_W-1:0] cfgValue,
  input  logic [SIG_W-1:0] cfgCare,
  input  logic             cfgValid,
  input  logic [SIG_W-1:0] sigVec,
  input  logic [LEN_W-1:0] fallbackLen,
  input  ctlStrb_t         strb,
  output logic             anyMatch,
  output logic             exitLast,
  output logic [HIT_W-1:0] hitCount
);

  logic [N_ENT-1:0] matchVec;
  logic [LEN_W-1:0] exitCnt;

  // one ternary entry per table slot
  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic [SIG_W-1:0] entVal;
    logic [SIG_W-1:0] entCare;
    logic             entVld;
    logic             wrHere;

    assign wrHere = cfgWrEn && (cfgIdx == IDX_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entVal  <= '0;
        entCare <= '0;
        entVld  <= 1'b0;
      end else if (wrHere) begin
        entVal  <= cfgValue;
        entCare <= cfgCare;
        entVld  <= cfgValid;
      end
    end

    // slot under write is masked for this cycle
    assign matchVec[e] = entVld && !wrHere &&
                         (((sigVec ^ entVal) & entCare) == '0);
  end

  assign anyMatch = |matchVec;

  // saturating match counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitCount <= '0;
    end else if (strb.hitInc && (hitCount != '1)) begin
      hitCount <= hitCount + 1'b1;
    end
  end

  // remaining retirements of the fallback episode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exitCnt <= '0;
    end else if (strb.exitLoad) begin
      exitCnt <= fallbackLen;
    end else if (strb.exitDec && (exitCnt != '0)) begin
      exitCnt <= exitCnt - 1'b1;
    end
  end

  assign exitLast = (exitCnt <= LEN_W'(1));

  // R10
  hit_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitCount == '1) |=> (hitCount == '1));

  // R10
  hit_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitCount != '1) |=> ((hitCount == $past(hitCount)) ||
                          (hitCount == $past(hitCount) + 1'b1)));

  // R4
  write_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && (cfgIdx == '0) && !(|matchVec[N_ENT-1:1])) |-> !anyMatch);

endmodule

// File: rtl/fpg_mode_ctrl.sv
`timescale 1ns/1ps
module fpg_mode_ctrl
  import fpg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     anyMatch,
  input  logic     exitLast,
  input  logic     drainDone,
  input  logic     retireValid,
  input  logic     exitAck,
  output ctlStrb_t strb,
  output logic     drainReq,
  output logic     fallbackActive,
  output logic     exitReq
);

  mode_e modeQ;
  mode_e modeNxt;
  logic  leaveFb;

  always_comb begin
    modeNxt       = modeQ;
    strb          = '0;
    strb.hitInc   = anyMatch;
    unique case (modeQ)
      MODE_NORMAL: begin
        if (anyMatch) modeNxt = MODE_DRAIN;
      end
      MODE_DRAIN: begin
        if (drainDone) begin
          modeNxt       = MODE_FALLBACK;
          strb.exitLoad = 1'b1;
        end
      end
      MODE_FALLBACK: begin
        if (retireValid) begin
          strb.exitDec = 1'b1;
          if (exitLast) modeNxt = MODE_NORMAL;
        end
      end
      default: modeNxt = MODE_NORMAL;
    endcase
  end

  assign leaveFb = (modeQ == MODE_FALLBACK) && retireValid && exitLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= MODE_NORMAL;
      exitReq <= 1'b0;
    end else begin
      modeQ <= modeNxt;
      if (leaveFb)      exitReq <= 1'b1;
      else if (exitAck) exitReq <= 1'b0;
    end
  end

  assign drainReq       = (modeQ == MODE_DRAIN);
  assign fallbackActive = (modeQ == MODE_FALLBACK);

  // R5
  normal_to_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!drainReq && !fallbackActive && anyMatch) |=> drainReq);

  // R9
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (drainReq && !drainDone) |=> (drainReq && !fallbackActive));

  // R6
  drain_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (drainReq && drainDone) |=> (fallbackActive && !drainReq));

  // R8
  exit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (exitReq && !exitAck) |=> exitReq);

  // R9
  fb_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fallbackActive && !retireValid) |=> fallbackActive);

endmodule

// File: rtl/fault_pattern_guard.sv
`timescale 1ns/1ps
module fault_pattern_guard
  import fpg_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int SIG_W = 32,
  parameter int HIT_W = 8,
  parameter int LEN_W = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [SIG_W-1:0] cfgValue,
  input  logic [SIG_W-1:0] cfgCare,
  input  logic             cfgValid,
  input  logic [LEN_W-1:0] fallbackLen,
  input  logic [SIG_W-1:0] sigVec,
  input  logic             drainDone,
  input  logic             retireValid,
  input  logic             exitAck,
  output logic             drainReq,
  output logic             fallbackActive,
  output logic             exitReq,
  output logic [HIT_W-1:0] hitCount
);

  ctlStrb_t strb;
  logic     anyMatch;
  logic     exitLast;

  fpg_datapath #(
    .N_ENT(N_ENT), .SIG_W(SIG_W), .HIT_W(HIT_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx), .cfgValue(cfgValue),
    .cfgCare(cfgCare), .cfgValid(cfgValid),
    .sigVec(sigVec), .fallbackLen(fallbackLen), .strb(strb),
    .anyMatch(anyMatch), .exitLast(exitLast), .hitCount(hitCount)
  );

  fpg_mode_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .anyMatch(anyMatch), .exitLast(exitLast),
    .drainDone(drainDone), .retireValid(retireValid), .exitAck(exitAck),
    .strb(strb), .drainReq(drainReq), .fallbackActive(fallbackActive),
    .exitReq(exitReq)
  );

endmodule

// File: tb/fault_pattern_guard_tb.sv
`timescale 1ns/1ps
module fault_pattern_guard_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgIdx = '0;
  logic [31:0] cfgValue = '0;
  logic [31:0] cfgCare = '0;
  logic        cfgValid = 1'b0;
  logic [15:0] fallbackLen = '0;
  logic [31:0] sigVec = '0;
  logic        drainDone = 1'b0;
  logic        retireValid = 1'b0;
  logic        exitAck = 1'b0;
  logic        drainReq, fallbackActive, exitReq;
  logic [7:0]  hitCount;

  int checks = 0;
  int failures = 0;
  int expHits = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fault_pattern_guard u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx),
    .cfgValue(cfgValue), .cfgCare(cfgCare), .cfgValid(cfgValid),
    .fallbackLen(fallbackLen), .sigVec(sigVec), .drainDone(drainDone),
    .retireValid(retireValid), .exitAck(exitAck), .drainReq(drainReq),
    .fallbackActive(fallbackActive), .exitReq(exitReq), .hitCount(hitCount)
  );

  // {expect a hit, signal vector}, checked while in fallback mode
  localparam logic [32:0] VEC [0:7] = '{
    {1'b1, 32'h1234_00A5},  // low byte compared, rest don't-care
    {1'b0, 32'h0000_00A4},  // one compared bit wrong
    {1'b1, 32'hDEAD_BEEF},  // upper half compared
    {1'b0, 32'hDEAC_0000},  // one upper bit wrong
    {1'b1, 32'h8000_0001},  // two scattered compared bits
    {1'b0, 32'h7FFF_FFFF},  // bit 31 wrong
    {1'b1, 32'hFFFF_FFFF},  // scattered bits satisfied
    {1'b0, 32'h0000_0000}   // only the invalid entry would match
  };

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int satInc(input int v, input bit hit);
    return (hit && v < 255) ? v + 1 : v;
  endfunction

  task automatic wrEnt(input logic [3:0] idx, input logic [31:0] val,
                       input logic [31:0] care, input logic vld);
    cfgWrEn = 1'b1; cfgIdx = idx; cfgValue = val; cfgCare = care;
    cfgValid = vld;
    cyc();
    cfgWrEn = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    cyc(); cyc();
    chk("R1 drainReq", {31'b0, drainReq}, 0);
    chk("R1 fallbackActive", {31'b0, fallbackActive}, 0);
    chk("R1 exitReq", {31'b0, exitReq}, 0);
    chk("R1 hitCount", {24'b0, hitCount}, 0);
    rstN = 1'b1;
    sigVec = 32'h0;
    cyc(); cyc();
    chk("R1 no match from empty table", {24'b0, hitCount}, 0);
    chk("R1 no drain from empty table", {31'b0, drainReq}, 0);

    // program entries
    wrEnt(4'd0, 32'h0000_00A5, 32'h0000_00FF, 1'b1);
    wrEnt(4'd1, 32'hDEAD_0000, 32'hFFFF_0000, 1'b1);
    wrEnt(4'd3, 32'h8000_0001, 32'h8000_0001, 1'b1);
    wrEnt(4'd5, 32'h0000_0000, 32'h0000_0000, 1'b0);  // R3 invalid catch-all
    cyc();
    chk("R3 invalid catch-all ignored", {24'b0, hitCount}, 0);

    // R5 match in normal mode starts a drain
    sigVec = 32'h0000_00A5;
    cyc(); expHits = satInc(expHits, 1);
    sigVec = 32'h0;
    chk("R5 drainReq after match", {31'b0, drainReq}, 1);
    chk("R10 count first hit", {24'b0, hitCount}, expHits);
    cyc(); cyc(); cyc();
    chk("R5 drainReq held", {31'b0, drainReq}, 1);

    // R9 match while draining
    sigVec = 32'hDEAD_0001;
    cyc(); expHits = satInc(expHits, 1);
    sigVec = 32'h0;
    chk("R9 drain unchanged", {31'b0, drainReq}, 1);
    chk("R9 fallback unchanged", {31'b0, fallbackActive}, 0);
    chk("R10 count in drain", {24'b0, hitCount}, expHits);

    // R6 drain complete
    fallbackLen = 16'd5;
    drainDone = 1'b1;
    cyc();
    drainDone = 1'b0;
    fallbackLen = 16'd900;  // later changes must not matter
    chk("R6 fallbackActive", {31'b0, fallbackActive}, 1);
    chk("R6 drainReq dropped", {31'b0, drainReq}, 0);

    // R2 ternary table walk in fallback
    for (int i = 0; i < 8; i++) begin
      sigVec = VEC[i][31:0];
      cyc(); expHits = satInc(expHits, VEC[i][32]);
      chk($sformatf("R2 vector %0d", i), {24'b0, hitCount}, expHits);
      chk($sformatf("R9 fallback held %0d", i), {31'b0, fallbackActive}, 1);
    end
    sigVec = 32'h0;

    // R4 new entry not active in write cycle
    sigVec = 32'h0000_0055;
    wrEnt(4'd6, 32'h0000_0055, 32'h0000_00FF, 1'b1);
    chk("R4 no hit in write cycle", {24'b0, hitCount}, expHits);
    cyc(); expHits = satInc(expHits, 1);
    chk("R4 hit after write", {24'b0, hitCount}, expHits);
    // R4 old contents masked during rewrite
    sigVec = 32'h0000_00A5;
    wrEnt(4'd0, 32'h0000_0011, 32'h0000_00FF, 1'b1);
    chk("R4 old contents masked", {24'b0, hitCount}, expHits);
    cyc();
    chk("R4 old contents gone", {24'b0, hitCount}, expHits);
    sigVec = 32'h0000_0011;
    cyc(); expHits = satInc(expHits, 1);
    chk("R4 new contents match", {24'b0, hitCount}, expHits);
    // R3 invalidate entry 6
    sigVec = 32'h0000_0055;
    wrEnt(4'd6, 32'h0000_0055, 32'h0000_00FF, 1'b0);
    cyc();
    chk("R3 invalidated entry", {24'b0, hitCount}, expHits);
    sigVec = 32'h0;

    // R7 five retirements with gaps
    for (int r = 0; r < 4; r++) begin
      retireValid = 1'b1; cyc();
      retireValid = 1'b0; cyc();
    end
    chk("R7 still in fallback after 4", {31'b0, fallbackActive}, 1);
    chk("R7 no exitReq yet", {31'b0, exitReq}, 0);
    retireValid = 1'b1; cyc(); retireValid = 1'b0;
    chk("R7 fallback ended", {31'b0, fallbackActive}, 0);
    chk("R7 exitReq raised", {31'b0, exitReq}, 1);

    // R8 handshake
    cyc(); cyc(); cyc();
    chk("R8 exitReq held", {31'b0, exitReq}, 1);
    exitAck = 1'b1; cyc(); exitAck = 1'b0;
    chk("R8 exitReq cleared", {31'b0, exitReq}, 0);

    // R7 zero length behaves as one
    sigVec = 32'h0000_0011;
    cyc(); expHits = satInc(expHits, 1);
    sigVec = 32'h0;
    fallbackLen = 16'd0;
    drainDone = 1'b1; cyc(); drainDone = 1'b0;
    chk("R7 zero-length fallback entered", {31'b0, fallbackActive}, 1);
    retireValid = 1'b1; cyc(); retireValid = 1'b0;
    chk("R7 zero-length exit", {31'b0, fallbackActive}, 0);
    chk("R7 zero-length exitReq", {31'b0, exitReq}, 1);
    exitAck = 1'b1; cyc(); exitAck = 1'b0;

    // R10 saturation
    sigVec = 32'h0000_0011;
    for (int k = 0; k < 300; k++) begin
      cyc(); expHits = satInc(expHits, 1);
    end
    sigVec = 32'h0;
    chk("R10 saturated", {24'b0, hitCount}, 255);
    chk("R10 model agrees", {24'b0, hitCount}, expHits);
    chk("R9 still draining", {31'b0, drainReq}, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule